// File: doc/BRIEF.md
# Trip-Zone Flag and Interrupt Controller

This block keeps the fault-trip state of one PWM channel. Two trip sources can set it. Dedicated hardware request inputs set it, and software can set it by writing a force register. It keeps three pieces of state:

- a sticky one-shot trip flag;
- a cycle-by-cycle trip flag, plus a live cycle-by-cycle trip output that is released at PWM period boundaries;
- a global interrupt flag, which gates a single-cycle interrupt pulse.

Output-forcing logic elsewhere in the channel uses the trip outputs to drive the PWM pins to a safe level. Software reads a status register to find out which trip occurred. It acknowledges trips by writing ones to a clear register.

The interrupt flag works as a gate. A pulse is issued only when the flag goes from clear to set. If software clears the interrupt flag while a trip flag is still set, the flag is set again at once and a new pulse is issued. Only clearing every flag stops further interrupts until the next trip.

Top module: `trip_flag_ctrl`

## Requirements
- R1: In reset, and on the first cycle after it, every flag reads 0, both trip outputs are low and the interrupt output is low.
- R2: Register addresses are as follows. Address 0 is status, with bit 2 the one-shot flag, bit 1 the cycle-by-cycle flag and bit 0 the interrupt flag. Address 1 is clear and address 2 is force. Reading clear or force returns 0. Bits 15..3 of every read are 0.
- R3: Writing force with bit 2 = 1 sets the one-shot flag and the one-shot output. Bit 1 = 1 sets the cycle-by-cycle flag and output. Bit 0, bits 15..3 and zero bits have no effect.
- R4: A one-shot or cycle-by-cycle request input held high in a cycle sets the matching flag and output at the next clock edge.
- R5: Writing clear with bit 2, bit 1 or bit 0 = 1 clears the one-shot, cycle-by-cycle or interrupt flag respectively. Zero bits leave the flags unchanged.
- R6: The one-shot flag and output stay set, through period strobes, until software clears them.
- R7: The cycle-by-cycle output drops at a period strobe that has no cycle-by-cycle request or force in the same cycle. The cycle-by-cycle flag stays set until software clears it.
- R8: A trip of either kind while the interrupt flag is clear sets that flag and gives an interrupt pulse exactly one cycle long.
- R9: While the interrupt flag stays set and is not cleared, no interrupt pulse is issued, whatever trips occur.
- R10: Clearing the interrupt flag while either trip flag is still set sets the interrupt flag again and issues a new pulse.
- R11: After both trip flags and the interrupt flag are cleared, no pulse occurs until a new trip event.
- R12: A trip set and a software clear of the same flag in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (2) | Write register address |
| wr_data | input | DATA_W (16) | Write data |
| rd_addr | input | ADDR_W (2) | Read register address |
| rd_data | output | DATA_W (16) | Read data, combinational from rd_addr |
| os_req | input | 1 | Hardware one-shot trip request |
| cbc_req | input | 1 | Hardware cycle-by-cycle trip request |
| period_strobe | input | 1 | PWM period-boundary strobe |
| os_trip | output | 1 | One-shot trip active |
| cbc_trip | output | 1 | Cycle-by-cycle trip active |
| trip_irq | output | 1 | Single-cycle interrupt pulse |

## Verification
Two pairs of functions can meet on the same edge. The first pair is a trip set and a software clear: a hardware request or force for a flag can coincide with a clear write for that same flag. The second pair is a clear of the interrupt flag and trip flags that are still set, which is the re-raise case. The bench drives each pair in one cycle: a clear write together with a hardware request, a period strobe together with a live cycle-by-cycle request, and an interrupt-only clear while trips are held. A reference model predicts, from the requirements, the status word, the trip outputs and the interrupt pulse after each edge, and a scoreboard compares them one cycle at a time.

// File: rtl/trip_flag_pkg.sv
package trip_flag_pkg;
   typedef enum logic [1:0] {
      REG_STATUS = 2'd0,
      REG_CLEAR  = 2'd1,
      REG_FORCE  = 2'd2
   } trip_reg_e;

   localparam int BIT_OS  = 2;
   localparam int BIT_CBC = 1;
   localparam int BIT_IRQ = 0;
endpackage

// File: rtl/trip_reg_port.sv
module trip_reg_port
   import trip_flag_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              st_os,
   input  logic              st_cbc,
   input  logic              st_irq,
   output logic              frc_os,
   output logic              frc_cbc,
   output logic              clr_os,
   output logic              clr_cbc,
   output logic              clr_irq,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
   localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(REG_CLEAR);
   localparam logic [ADDR_W-1:0] A_FORCE  = ADDR_W'(REG_FORCE);

   if (DATA_W < 3) begin : g_bad_data_w
      $error("trip_reg_port: DATA_W must hold three flag bits");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("trip_reg_port: ADDR_W must decode three registers");
   end

   logic wr_clear, wr_force;

   always_comb begin
      wr_clear = wr_en && (wr_addr == A_CLEAR);
      wr_force = wr_en && (wr_addr == A_FORCE);
      clr_os   = wr_clear && wr_data[BIT_OS];
      clr_cbc  = wr_clear && wr_data[BIT_CBC];
      clr_irq  = wr_clear && wr_data[BIT_IRQ];
      frc_os   = wr_force && wr_data[BIT_OS];
      frc_cbc  = wr_force && wr_data[BIT_CBC];
   end

   // Clear and force are write-only strobes: they read back as zero.
   always_comb begin
      rd_data = '0;
      if (rd_addr == A_STATUS) begin
         rd_data[BIT_OS]  = st_os;
         rd_data[BIT_CBC] = st_cbc;
         rd_data[BIT_IRQ] = st_irq;
      end
   end

   always_comb begin
      assert_rsvd_zero_R2: assert ((rd_data >> 3) == '0);
   end
endmodule

// File: rtl/trip_latch.sv
module trip_latch #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q,
   output logic q_next
);
   if (SET_WINS) begin : g_set_wins
      assign q_next = set | (q & ~clr);
   end else begin : g_clr_wins
      assign q_next = (q | set) & ~clr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_next;
   end

   if (SET_WINS) begin : g_set_chk
      assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
         set |=> q);
   end
   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q);
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!set && !clr) |=> $stable(q));
endmodule

// File: rtl/trip_irq_gen.sv
module trip_irq_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic any_trip_next,
   input  logic clr_irq,
   output logic irq_flag,
   output logic irq_pulse
);
   logic fire;

   // A pulse fires when the gate is open (flag clear, or being cleared)
   // and a trip flag will be set after this edge.
   assign fire = (~irq_flag | clr_irq) & any_trip_next;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_flag  <= 1'b0;
         irq_pulse <= 1'b0;
      end else begin
         irq_flag  <= (irq_flag & ~clr_irq) | fire;
         irq_pulse <= fire;
      end
   end

   assert_gate_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !clr_irq) |=> !irq_pulse);
   assert_pulse_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> irq_flag);
endmodule

// File: rtl/trip_flag_ctrl.sv
module trip_flag_ctrl #(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 2,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              os_req,
   input  logic              cbc_req,
   input  logic              period_strobe,
   output logic              os_trip,
   output logic              cbc_trip,
   output logic              trip_irq
);
   logic frc_os, frc_cbc, clr_os, clr_cbc, clr_irq;
   logic os_set, cbc_set;
   logic os_q, os_nx, cbcf_q, cbcf_nx, cbca_q, cbca_nx;
   logic irq_flag;

   assign os_set  = os_req  | frc_os;
   assign cbc_set = cbc_req | frc_cbc;

   trip_reg_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .st_os(os_q), .st_cbc(cbcf_q), .st_irq(irq_flag),
      .frc_os(frc_os), .frc_cbc(frc_cbc),
      .clr_os(clr_os), .clr_cbc(clr_cbc), .clr_irq(clr_irq),
      .rd_data(rd_data)
   );

   // Sticky one-shot flag, also the one-shot trip output.
   trip_latch #(.SET_WINS(SET_WINS)) u_os (
      .clk(clk), .rst_n(rst_n), .set(os_set), .clr(clr_os),
      .q(os_q), .q_next(os_nx)
   );

   // Cycle-by-cycle status flag, cleared by software.
   trip_latch #(.SET_WINS(SET_WINS)) u_cbc_flag (
      .clk(clk), .rst_n(rst_n), .set(cbc_set), .clr(clr_cbc),
      .q(cbcf_q), .q_next(cbcf_nx)
   );

   // Cycle-by-cycle trip output, released at a period boundary.
   trip_latch #(.SET_WINS(1'b1)) u_cbc_act (
      .clk(clk), .rst_n(rst_n), .set(cbc_set), .clr(period_strobe),
      .q(cbca_q), .q_next(cbca_nx)
   );

   trip_irq_gen u_irq (
      .clk(clk), .rst_n(rst_n), .any_trip_next(os_nx | cbcf_nx),
      .clr_irq(clr_irq), .irq_flag(irq_flag), .irq_pulse(trip_irq)
   );

   assign os_trip  = os_q;
   assign cbc_trip = cbca_q;

   assert_flags_imply_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (os_q || cbcf_q) |-> irq_flag);
   assert_first_trip_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_flag && (os_req || cbc_req)) |=> trip_irq);
   assert_cbc_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (period_strobe && !cbc_req && !frc_cbc) |=> !cbc_trip);
   assert_os_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (os_trip && !clr_os) |=> os_trip);
endmodule

// File: tb/trip_flag_ctrl_tb.sv
`timescale 1ns/1ps
module trip_flag_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        os_req = 1'b0, cbc_req = 1'b0, period_strobe = 1'b0;
   logic        os_trip, cbc_trip, trip_irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [15:0] rd;
      logic        os;
      logic        cbc;
      logic        irq;
      string       tag;
   } exp_t;
   exp_t sb[$];

   // Reference state
   bit m_os, m_cf, m_ca, m_irq;

   always #2.5 clk = ~clk;

   trip_flag_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .os_req(os_req), .cbc_req(cbc_req), .period_strobe(period_strobe),
      .os_trip(os_trip), .cbc_trip(cbc_trip), .trip_irq(trip_irq)
   );

   task automatic step(input bit we, input logic [1:0] wa, input logic [15:0] wd,
                       input logic [1:0] ra, input bit osr, input bit cbr,
                       input bit st, input string tag);
      bit os_set, cbc_set, os_clr, cf_clr, irq_clr, pulse;
      exp_t e;
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
      os_req = osr; cbc_req = cbr; period_strobe = st;
      os_set  = osr || (we && wa == 2'd2 && wd[2]);
      cbc_set = cbr || (we && wa == 2'd2 && wd[1]);
      os_clr  = we && wa == 2'd1 && wd[2];
      cf_clr  = we && wa == 2'd1 && wd[1];
      irq_clr = we && wa == 2'd1 && wd[0];
      m_os = os_set ? 1'b1 : (os_clr ? 1'b0 : m_os);
      m_cf = cbc_set ? 1'b1 : (cf_clr ? 1'b0 : m_cf);
      m_ca = cbc_set ? 1'b1 : (st ? 1'b0 : m_ca);
      pulse = (!m_irq || irq_clr) && (m_os || m_cf);
      m_irq = (m_irq && !irq_clr) || pulse;
      e.rd  = (ra == 2'd0) ? {13'd0, m_os, m_cf, m_irq} : 16'd0;
      e.os  = m_os;
      e.cbc = m_ca;
      e.irq = pulse;
      e.tag = tag;
      sb.push_back(e);
      @(posedge clk);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 2'd0, 16'd0, 2'd0, 1'b0, 1'b0, 1'b0, tag);
   endtask

   // Monitor: pop one expected item per clock edge and compare after it.
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         total++;
         if (rd_data !== e.rd || os_trip !== e.os || cbc_trip !== e.cbc ||
             trip_irq !== e.irq) begin
            bad++;
            $display("FAIL %s: got rd=%h os=%b cbc=%b irq=%b exp rd=%h os=%b cbc=%b irq=%b",
                     e.tag, rd_data, os_trip, cbc_trip, trip_irq,
                     e.rd, e.os, e.cbc, e.irq);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      total++;
      if (rd_data !== 16'd0 || os_trip !== 1'b0 || cbc_trip !== 1'b0 || trip_irq !== 1'b0) begin
         bad++;
         $display("FAIL R1 in reset: rd=%h os=%b cbc=%b irq=%b exp all 0",
                  rd_data, os_trip, cbc_trip, trip_irq);
      end
      @(negedge clk); rst_n = 1'b1;
      idle("R1 after reset");
      // Hardware one-shot request: flag, output, first pulse.
      step(0, 0, 0, 0, 1, 0, 0, "R4 R8 os request");
      idle("R8 pulse is one cycle");
      step(0, 0, 0, 0, 0, 0, 1, "R6 os survives strobe");
      step(0, 0, 0, 0, 0, 1, 0, "R9 cbc trip with irq set");
      step(0, 0, 0, 0, 0, 0, 1, "R7 cbc released at strobe");
      step(0, 0, 0, 1, 0, 0, 0, "R2 clear reads 0");
      step(0, 0, 0, 2, 0, 0, 0, "R2 force reads 0");
      // Clearing the interrupt flag alone with trips held.
      step(1, 1, 16'h0001, 0, 0, 0, 0, "R10 irq re-raised");
      step(1, 1, 16'h0000, 0, 0, 0, 0, "R5 zero clear ignored");
      step(1, 1, 16'h0007, 0, 0, 0, 0, "R11 R5 clear all");
      idle("R11 quiet");
      step(0, 0, 0, 0, 0, 0, 1, "R11 quiet at strobe");
      // Force register.
      step(1, 2, 16'hFFF9, 0, 0, 0, 0, "R3 reserved force bits ignored");
      step(1, 2, 16'h0004, 2, 0, 0, 0, "R3 R8 force os, readback 0");
      step(1, 1, 16'h0006, 0, 0, 0, 0, "R5 clear trips keep irq");
      step(1, 2, 16'h0002, 0, 0, 0, 0, "R3 R9 force cbc no pulse");
      // Simultaneous set and clear of the same flag.
      step(1, 1, 16'h0004, 0, 1, 0, 0, "R12 os set beats clear");
      step(1, 1, 16'h0002, 0, 0, 1, 1, "R12 R7 cbc set beats clear and strobe");
      step(0, 0, 0, 0, 0, 0, 1, "R7 strobe releases cbc");
      step(1, 1, 16'h0006, 0, 0, 0, 0, "R5 clear trips");
      step(1, 1, 16'h0001, 0, 0, 0, 0, "R11 clear irq no pulse");
      step(0, 0, 0, 0, 0, 1, 0, "R4 R8 cbc request pulse");
      step(1, 1, 16'h0003, 0, 0, 0, 0, "R11 clear cbc and irq");
      step(1, 1, 16'h0001, 0, 0, 1, 0, "R12 R10 irq clear with new cbc");
      idle("R9 no pulse after");
      idle("drain");
      idle("drain");
      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule